// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Prescaler

This block takes a fast source clock and produces one clock-enable strobe that paces the CPU and every synchronous peripheral together. The strobe is high for one source cycle out of every 2^k, where k is a divide code held in the block. A counter inside the block runs at the full source rate and marks the end of each divided period.

Software can request a new ratio at any time by pulsing a write strobe with a new code. The request is held until the current divided period ends. The counter then restarts, so the first period at the new ratio has its full length. As a result, every period the strobe ever produces is exactly the old length or exactly the new length. No runt period and no glitch can reach the clocked logic. A status output shows which code is actually in force. While a request is waiting, that code can differ from the code most recently written.

Top module: `clkdiv_switch`

## Requirements
- R1: While reset is low, and right after it is released, the active code is 0 (divide-by-1) and sys_en is high on every source cycle.
- R2: With active code c (0 to MAX_CODE, default 8), sys_en is high for exactly one source cycle in every 2^c cycles, giving ratios 1, 2, 4, ..., 256.
- R3: A write whose code is above MAX_CODE (9 to 15 by default) is ignored. It changes neither the active code, the strobe rhythm nor a request already waiting.
- R4: div_act changes only on the source edge that directly follows a cycle in which sys_en was high.
- R5: Every interval between two sys_en pulses is exactly 2^old or 2^new cycles. The first interval after a switch is a full 2^new.
- R6: A write sampled on a source edge takes effect on the edge after the first sys_en cycle that comes later than that edge. From 32 to 2, with the write placed in the cycle just after a pulse, div_act shows the new code 33 cycles after the write is driven.
- R7: A second legal write made while a request is waiting replaces that request. Only the last code written becomes active.
- R8: div_act reports the code in force, not a code that is still waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Undivided source clock |
| rst_src_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | One-cycle strobe that requests a new divide code |
| div_sel | input | SEL_W | Requested divide code (log2 of the ratio) |
| sys_en | output | 1 | Divided clock enable, one source cycle per divided period |
| div_act | output | SEL_W | Divide code currently in force |

## Verification
The bench builds the block with its defaults: a 4-bit code and a largest code of 8. This brings the full divide-by-256 period within reach, and it leaves seven codes (9 to 15) for the reserved-write cases. A cycle model fed from the same stimulus predicts the strobe and the status on every cycle. This covers switches between the slowest and fastest ratios in both directions. Directed steps pin down the 33-cycle latency case, replacement of a waiting request, and reserved writes that arrive while a request is waiting.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   // counter width needed for the largest ratio (at least one bit)
   function automatic int unsigned cd_cnt_w(input int unsigned max_code);
      return (max_code < 1) ? 1 : max_code;
   endfunction

   // pending request held between a write and the next divided edge
   typedef struct packed {
      logic       vld;
      logic [7:0] code;
   } cd_req_t;
endpackage

// File: rtl/clkdiv_req_hold.sv
module clkdiv_req_hold
   import clkdiv_pkg::*;
#(
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned MAX_CODE = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             take_i,
   output logic             pend_vld_o,
   output logic [SEL_W-1:0] pend_code_o
);
   localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(MAX_CODE);

   cd_req_t req_q;
   logic    legal;

   assign legal = (sel_i <= TOP_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
      end else if (wr_i && legal) begin
         // newest legal write wins, even on the edge that consumes the old one
         req_q.vld  <= 1'b1;
         req_q.code <= 8'(sel_i);
      end else if (take_i) begin
         req_q.vld <= 1'b0;
      end
   end

   assign pend_vld_o  = req_q.vld;
   assign pend_code_o = req_q.code[SEL_W-1:0];
endmodule

// File: rtl/clkdiv_ctr.sv
module clkdiv_ctr
   import clkdiv_pkg::*;
#(
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned MAX_CODE = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] code_i,
   output logic             term_o
);
   localparam int unsigned CNT_W = cd_cnt_w(MAX_CODE);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // terminal count is 2^code - 1: one bit per counter stage
   for (genvar i = 0; i < CNT_W; i++) begin : g_lim
      assign limit[i] = (code_i > SEL_W'(i));
   end

   assign term_o = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (term_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/clkdiv_switch.sv
module clkdiv_switch #(
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned MAX_CODE = 8
)(
   input  logic             clk_src,
   input  logic             rst_src_n,
   input  logic             div_wr,
   input  logic [SEL_W-1:0] div_sel,
   output logic             sys_en,
   output logic [SEL_W-1:0] div_act
);
   if (SEL_W < 1 || SEL_W > 8) begin : g_bad_w
      $error("clkdiv_switch: SEL_W must be 1..8");
   end
   if (MAX_CODE < 1 || MAX_CODE >= (1 << SEL_W)) begin : g_bad_max
      $error("clkdiv_switch: MAX_CODE must fit in SEL_W bits and be at least 1");
   end

   logic             term;
   logic             pend_vld;
   logic [SEL_W-1:0] pend_code;
   logic [SEL_W-1:0] act_q;
   logic             apply;

   assign apply = term && pend_vld;

   clkdiv_req_hold #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE)) u_req (
      .clk        (clk_src),
      .rst_n      (rst_src_n),
      .wr_i       (div_wr),
      .sel_i      (div_sel),
      .take_i     (apply),
      .pend_vld_o (pend_vld),
      .pend_code_o(pend_code)
   );

   clkdiv_ctr #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE)) u_ctr (
      .clk    (clk_src),
      .rst_n  (rst_src_n),
      .code_i (act_q),
      .term_o (term)
   );

   // ratio swaps only at a divided edge; counter restarts on that same edge
   always_ff @(posedge clk_src or negedge rst_src_n) begin
      if (!rst_src_n)  act_q <= '0;
      else if (apply)  act_q <= pend_code;
   end

   assign sys_en  = term;
   assign div_act = act_q;
endmodule

// File: rtl/clkdiv_switch_chk.sv
module clkdiv_switch_chk #(
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned MAX_CODE = 8
)(
   input logic             clk_src,
   input logic             rst_src_n,
   input logic             div_wr,
   input logic [SEL_W-1:0] div_sel,
   input logic             sys_en,
   input logic [SEL_W-1:0] div_act
);
   localparam int unsigned GW = MAX_CODE + 1;

   logic [GW-1:0] gap_q;
   logic [GW-1:0] span;

   assign span = (GW'(1) << div_act) - GW'(1);

   always_ff @(posedge clk_src or negedge rst_src_n) begin
      if (!rst_src_n)   gap_q <= '0;
      else if (sys_en)  gap_q <= '0;
      else              gap_q <= gap_q + 1'b1;
   end

   p_ceiling_r2: assert property (@(posedge clk_src) disable iff (!rst_src_n)
      div_act <= SEL_W'(MAX_CODE));

   p_hold_r4: assert property (@(posedge clk_src) disable iff (!rst_src_n)
      !$stable(div_act) |-> $past(sys_en));

   p_full_period_r5: assert property (@(posedge clk_src) disable iff (!rst_src_n)
      sys_en |-> gap_q == span);

   p_no_overrun_r5: assert property (@(posedge clk_src) disable iff (!rst_src_n)
      gap_q <= span);

   p_reserved_quiet_r3: assert property (@(posedge clk_src) disable iff (!rst_src_n)
      (div_wr && div_sel > SEL_W'(MAX_CODE) && !sys_en) |=> $stable(div_act));
endmodule

bind clkdiv_switch clkdiv_switch_chk #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE)) u_chk (.*);

// File: tb/clkdiv_switch_bench.sv
module clkdiv_switch_bench;
   localparam int SEL_W    = 4;
   localparam int MAX_CODE = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             div_wr = 1'b0;
   logic [SEL_W-1:0] div_sel = '0;
   logic             sys_en;
   logic [SEL_W-1:0] div_act;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   clkdiv_switch #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE)) u_clkdiv_switch (
      .clk_src(clk), .rst_src_n(rst_n), .div_wr(div_wr), .div_sel(div_sel),
      .sys_en(sys_en), .div_act(div_act)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- reference model (from the requirements) ------------
   typedef struct packed { logic en; logic [SEL_W-1:0] code; } exp_t;
   exp_t exp_q[$];

   int m_cnt, m_code, m_pc;
   bit m_pv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_code = 0; m_pv = 0; m_pc = 0;
         exp_q.delete();
      end else begin
         bit edge_now;
         edge_now = (m_cnt == (1 << m_code) - 1);
         if (edge_now) begin
            m_cnt = 0;
            if (m_pv) begin m_code = m_pc; m_pv = 0; end
         end else m_cnt++;
         if (div_wr && int'(div_sel) <= MAX_CODE) begin m_pv = 1; m_pc = int'(div_sel); end
         exp_q.push_back({(m_cnt == (1 << m_code) - 1), SEL_W'(m_code)});
      end
   end

   // monitor: compares outputs with the model between edges
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(sys_en == e.en, "R5", "sys_en rhythm", int'(sys_en), int'(e.en));
         check(div_act == e.code, "R4", "div_act timing", int'(div_act), int'(e.code));
      end
   end

   // ---------------- driver ----------------------------------------------
   task automatic do_write(input int code);
      div_wr  = 1'b1;
      div_sel = SEL_W'(code);
      @(negedge clk);
      div_wr  = 1'b0;
   endtask

   task automatic wait_act(input int code);
      for (int i = 0; i < 2000 && int'(div_act) != code; i++) @(negedge clk);
   endtask

   task automatic wait_en();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (sys_en) break;
      end
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(sys_en == 1'b1, "R1", "sys_en in reset", int'(sys_en), 1);
      check(div_act == 0, "R1", "div_act in reset", int'(div_act), 0);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(sys_en == 1'b1, "R1", "sys_en after reset", int'(sys_en), 1);
      end

      // R2: every ratio, measured pulse to pulse
      for (int c = 0; c <= MAX_CODE; c++) begin
         do_write(c);
         wait_act(c);
         wait_en();
         n = 0;
         do begin @(negedge clk); n++; end while (!sys_en && n < 1000);
         check(n == (1 << c), "R2", $sformatf("period code %0d", c), n, 1 << c);
      end

      // R8 and R7: at divide-by-256 a waiting request is not reported, then replaced
      do_write(2);
      check(div_act == 8, "R8", "status while pending", int'(div_act), 8);
      do_write(5);
      check(div_act == 8, "R8", "status after rewrite", int'(div_act), 8);
      for (int i = 0; i < 2000 && int'(div_act) == 8; i++) @(negedge clk);
      check(div_act == 5, "R7", "replaced request", int'(div_act), 5);

      // R6: latency from 32 to 2 with the write just after a pulse
      wait_en();
      div_wr = 1'b1; div_sel = SEL_W'(1);
      @(negedge clk);
      div_wr = 1'b0;
      n = 1;
      while (int'(div_act) != 1 && n < 1000) begin @(negedge clk); n++; end
      check(n == 33, "R6", "switch latency", n, 33);

      // R3: reserved code alone changes nothing
      do_write(15);
      repeat (20) @(negedge clk);
      check(div_act == 1, "R3", "reserved write ignored", int'(div_act), 1);
      // R3: reserved code does not cancel a waiting request
      wait_en();
      do_write(4);
      do_write(12);
      do_write(9);
      wait_act(4);
      check(div_act == 4, "R3", "pending kept over reserved", int'(div_act), 4);

      // R5: slow-to-fast and fast-to-slow sweeps under the scoreboard
      do_write(0); wait_act(0);
      do_write(8); wait_act(8);
      wait_en();
      do_write(3); wait_act(3);
      repeat (40) @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule